// File: doc/BRIEF.md
# Nested Dual-Rate PWM Channel Generator

This block produces the on/off drive for a bank of LED channels from two nested pulse-width layers. A slow 8-bit layer splits its period into 2^SLOT_W slots. Each slot holds one complete period of a fast layer, which is either wide (FAST_W bits) or narrow (FAST_W-2 bits). A channel is lit only when its fast duty and its slow duty both allow it. The average on-fraction is therefore (fast duty / N) × (slow duty / 2^SLOT_W).

The block has one shared prescaler, one fast counter and one slot counter, plus a comparator for each channel. Global controls choose the layer combination, the resolution, the fast-rate divider in narrow mode, and whether the channels of each RGB triplet share the duty values of the triplet's first channel. Duty and control inputs are plain levels. They are captured into shadow state only at the start of a slow period, so a period is never cut short. When `run` is low, every output is dark and the counters are held at zero. The duty and control levels stay with the driver, so nothing is lost. All inputs are sampled every cycle and there is no handshake.

Top module: `dual_pwm_gen`

## Requirements
- R1: The fast counter steps through N positions: N = 2^FAST_W when `wide_res`=1 and N = 2^(FAST_W-2) when it is 0. The slot counter advances once per fast period through 2^SLOT_W slots. Both counters start at 0 in the first cycle that `run` is seen high.
- R2: The fast counter advances once every D clocks. D = 1 in wide mode, whatever `freq_sel` holds. In narrow mode `freq_sel` 00 gives D=4, 01 gives D=2, and 10 or 11 gives D=1. One slow period lasts D·N·2^SLOT_W clocks.
- R3: With `mode_sel`=00 (nested), a channel is on exactly when fast position < fast duty and slot < slow duty.
- R4: In narrow mode only the low FAST_W-2 bits of a channel's fast duty are used. The upper two bits have no effect on the output.
- R5: With `mode_sel`=01 the slot test is skipped (slow duty taken as full) and only the fast test applies. 10 holds every channel on. 11 holds every channel off.
- R6: With `rgb_group`=1, channels 3k, 3k+1 and 3k+2 all take both duties from channel 3k.
- R7: While `run` is 0 all outputs are 0 and the counters are held at 0.
- R8: Duty values and all four control inputs are captured only in a cycle where `run` is 0 or the last cycle of a slow period. A change at any other time takes effect at the next period start.
- R9: In nested mode a channel is on for exactly D·fast_duty_eff·slow_duty clocks of each slow period.
- R10: During reset all outputs are 0, whatever the inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | 1 = generate; 0 = outputs dark, counters cleared |
| mode_sel | input | 2 | 00 nested, 01 fast only, 10 always on, 11 off |
| wide_res | input | 1 | 1 = FAST_W-bit fast layer, 0 = (FAST_W-2)-bit |
| freq_sel | input | 2 | Narrow-mode fast-rate divider select |
| rgb_group | input | 1 | 1 = triplets share the first channel's duties |
| fast_duty | input | NCH*FAST_W | Fast duty per channel, channel c at bits [c*FAST_W +: FAST_W] |
| slow_duty | input | NCH*SLOT_W | Slow duty per channel, channel c at bits [c*SLOT_W +: SLOT_W] |
| chan_on | output | NCH | Drive per channel, 1 = lit |

## Verification
The bench uses a small configuration and sweeps every combination of resolution, divider code, mode and grouping. It predicts each cycle's output arithmetically from the cycle count since `run` rose. Random duties are mixed with corners: full duty, zero fast duty and zero slow duty. A divider or wrap off by one would shift the on-window against the prediction. Fast duty leaking its high bits into narrow mode would light channels 0 and 1 too long. Duties changed mid-period are expected to wait for the boundary, so a design that updates at once would truncate the running period. Shutdown and restart are checked so that a counter that keeps its old position would show up as a phase error.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  typedef enum logic [1:0] {
    MODE_NESTED    = 2'b00,
    MODE_FAST_ONLY = 2'b01,
    MODE_DC        = 2'b10,
    MODE_OFF       = 2'b11
  } dpwm_mode_e;

  typedef struct packed {
    dpwm_mode_e  mode;
    logic        wide;
    logic [1:0]  fsel;
    logic        rgb;
  } dpwm_cfg_t;

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
  import dpwm_pkg::*;
#(
  parameter int FAST_W = 10,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  dpwm_cfg_t         cfg,
  output logic [FAST_W-1:0] fast_cnt,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic              period_end
);

  localparam logic [FAST_W-1:0] WIDE_LAST   = {FAST_W{1'b1}};
  localparam logic [FAST_W-1:0] NARROW_LAST = {2'b00, {(FAST_W-2){1'b1}}};

  logic [1:0]        pre_cnt;
  logic [1:0]        div_last;
  logic [FAST_W-1:0] fast_last;
  logic              step;
  logic              fast_wrap;

  always_comb begin
    if (cfg.wide)              div_last = 2'd0;
    else if (cfg.fsel == 2'b00) div_last = 2'd3;
    else if (cfg.fsel == 2'b01) div_last = 2'd1;
    else                        div_last = 2'd0;
  end

  assign fast_last  = cfg.wide ? WIDE_LAST : NARROW_LAST;
  assign step       = (pre_cnt == div_last);
  assign fast_wrap  = step && (fast_cnt == fast_last);
  assign period_end = run && fast_wrap && (&slot_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      fast_cnt <= '0;
      slot_cnt <= '0;
    end else if (!run) begin
      pre_cnt  <= '0;
      fast_cnt <= '0;
      slot_cnt <= '0;
    end else begin
      pre_cnt <= step ? 2'd0 : pre_cnt + 2'd1;
      if (fast_wrap) begin
        fast_cnt <= '0;
        slot_cnt <= slot_cnt + 1'b1;
      end else if (step) begin
        fast_cnt <= fast_cnt + 1'b1;
      end
    end
  end

  // R1: fast position never leaves the selected range
  a_r1_fast_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    fast_cnt <= fast_last);

  // R1: the slot only moves on a fast-period wrap
  a_r1_slot_moves_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    run && !fast_wrap |=> !run || $stable(slot_cnt));

  // R2: prescaler stays inside the divider window
  a_r2_prescale_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt <= div_last);

  // R7: counters are cleared while stopped
  a_r7_counters_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (fast_cnt == '0) && (slot_cnt == '0));

endmodule

// File: rtl/dpwm_shadow.sv
module dpwm_shadow #(
  parameter int NCH    = 36,
  parameter int FAST_W = 10,
  parameter int SLOT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    rgb_in,
  input  logic [NCH*FAST_W-1:0]   fast_in,
  input  logic [NCH*SLOT_W-1:0]   slow_in,
  output logic [NCH*FAST_W-1:0]   fast_q,
  output logic [NCH*SLOT_W-1:0]   slow_q
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int LEAD = (c / 3) * 3;
    logic [FAST_W-1:0] f_src;
    logic [SLOT_W-1:0] s_src;

    assign f_src = rgb_in ? fast_in[LEAD*FAST_W +: FAST_W] : fast_in[c*FAST_W +: FAST_W];
    assign s_src = rgb_in ? slow_in[LEAD*SLOT_W +: SLOT_W] : slow_in[c*SLOT_W +: SLOT_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fast_q[c*FAST_W +: FAST_W] <= '0;
        slow_q[c*SLOT_W +: SLOT_W] <= '0;
      end else if (load) begin
        fast_q[c*FAST_W +: FAST_W] <= f_src;
        slow_q[c*SLOT_W +: SLOT_W] <= s_src;
      end
    end

    // R8: shadow duties hold between capture points
    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(fast_q[c*FAST_W +: FAST_W]) && $stable(slow_q[c*SLOT_W +: SLOT_W]));

    if (c != LEAD) begin : g_member
      // R6: grouped capture gives the member its lead's duties
      a_r6_triplet_shared: assert property (@(posedge clk) disable iff (!rst_n)
        load && rgb_in |=> (fast_q[c*FAST_W +: FAST_W] == fast_q[LEAD*FAST_W +: FAST_W]) &&
                           (slow_q[c*SLOT_W +: SLOT_W] == slow_q[LEAD*SLOT_W +: SLOT_W]));
    end
  end

endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare
  import dpwm_pkg::*;
#(
  parameter int FAST_W = 10,
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  dpwm_mode_e        mode,
  input  logic              wide,
  input  logic [FAST_W-1:0] fast_cnt,
  input  logic [SLOT_W-1:0] slot_cnt,
  input  logic [FAST_W-1:0] fast_duty,
  input  logic [SLOT_W-1:0] slow_duty,
  output logic              on
);

  logic [FAST_W-1:0] duty_eff;
  logic              fast_ok;
  logic              slot_ok;
  logic              raw;

  assign duty_eff = wide ? fast_duty : {2'b00, fast_duty[FAST_W-3:0]};
  assign fast_ok  = fast_cnt < duty_eff;
  assign slot_ok  = slot_cnt < slow_duty;

  always_comb begin
    unique case (mode)
      MODE_NESTED:    raw = fast_ok && slot_ok;
      MODE_FAST_ONLY: raw = fast_ok;
      MODE_DC:        raw = 1'b1;
      default:        raw = 1'b0;
    endcase
  end

  assign on = run && raw;

  // R7: stopped channels are dark
  a_r7_dark_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !on);

  // R5: DC mode lights, off mode darkens
  a_r5_dc_lit: assert property (@(posedge clk) disable iff (!rst_n)
    run && (mode == MODE_DC) |-> on);
  a_r5_off_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> !on);

  // R3: a zero slow duty darkens nested mode entirely
  a_r3_zero_slow_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_NESTED) && (slow_duty == '0) |-> !on);

endmodule

// File: rtl/dual_pwm_gen.sv
module dual_pwm_gen
  import dpwm_pkg::*;
#(
  parameter int NCH    = 36,
  parameter int FAST_W = 10,
  parameter int SLOT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run,
  input  logic [1:0]            mode_sel,
  input  logic                  wide_res,
  input  logic [1:0]            freq_sel,
  input  logic                  rgb_group,
  input  logic [NCH*FAST_W-1:0] fast_duty,
  input  logic [NCH*SLOT_W-1:0] slow_duty,
  output logic [NCH-1:0]        chan_on
);

  dpwm_cfg_t         cfg_q;
  dpwm_cfg_t         cfg_d;
  logic              load;
  logic              period_end;
  logic [FAST_W-1:0] fast_cnt;
  logic [SLOT_W-1:0] slot_cnt;
  logic [NCH*FAST_W-1:0] fast_q;
  logic [NCH*SLOT_W-1:0] slow_q;

  assign cfg_d = '{mode: dpwm_mode_e'(mode_sel), wide: wide_res, fsel: freq_sel, rgb: rgb_group};
  assign load  = !run || period_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '{mode: MODE_NESTED, wide: 1'b0, fsel: 2'b00, rgb: 1'b0};
    else if (load) cfg_q <= cfg_d;
  end

  // R8: control fields only move at a capture point
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

  dpwm_timebase #(.FAST_W(FAST_W), .SLOT_W(SLOT_W)) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .cfg        (cfg_q),
    .fast_cnt   (fast_cnt),
    .slot_cnt   (slot_cnt),
    .period_end (period_end)
  );

  dpwm_shadow #(.NCH(NCH), .FAST_W(FAST_W), .SLOT_W(SLOT_W)) u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .rgb_in  (rgb_group),
    .fast_in (fast_duty),
    .slow_in (slow_duty),
    .fast_q  (fast_q),
    .slow_q  (slow_q)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_cmp
    dpwm_compare #(.FAST_W(FAST_W), .SLOT_W(SLOT_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .mode      (cfg_q.mode),
      .wide      (cfg_q.wide),
      .fast_cnt  (fast_cnt),
      .slot_cnt  (slot_cnt),
      .fast_duty (fast_q[c*FAST_W +: FAST_W]),
      .slow_duty (slow_q[c*SLOT_W +: SLOT_W]),
      .on        (chan_on[c])
    );
  end

endmodule

// File: tb/sim_dual_pwm_gen.sv
module sim_dual_pwm_gen;
  localparam int NCH = 6;
  localparam int FW  = 4;
  localparam int SW  = 3;
  localparam int NS  = 1 << SW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic [1:0] freq_sel = 2'b00;
  logic wide_res = 1'b0;
  logic rgb_group = 1'b0;
  logic [NCH*FW-1:0] fast_duty = '0;
  logic [NCH*SW-1:0] slow_duty = '0;
  logic [NCH-1:0] chan_on;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int cyc = 0;

  int fdv[NCH];
  int sdv[NCH];
  int nfd[NCH];
  int nsd[NCH];
  int e_mode, e_wide, e_fsel, e_rgb;

  always #5 clk = ~clk;

  dual_pwm_gen #(.NCH(NCH), .FAST_W(FW), .SLOT_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .run(run), .mode_sel(mode_sel), .wide_res(wide_res),
    .freq_sel(freq_sel), .rgb_group(rgb_group), .fast_duty(fast_duty),
    .slow_duty(slow_duty), .chan_on(chan_on)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
      finish_up();
    end
  end

  task automatic drive(input int f[NCH], input int s[NCH]);
    for (int c = 0; c < NCH; c++) begin
      fast_duty[c*FW +: FW] = FW'(f[c]);
      slow_duty[c*SW +: SW] = SW'(s[c]);
    end
  endtask

  function automatic int divv();
    if (e_wide != 0) return 1;
    if (e_fsel == 0) return 4;
    if (e_fsel == 1) return 2;
    return 1;
  endfunction

  function automatic int nfl();
    return (e_wide != 0) ? (1 << FW) : (1 << (FW - 2));
  endfunction

  function automatic int fde(int c);
    int src;
    src = (e_rgb != 0) ? (c / 3) * 3 : c;
    return (e_wide != 0) ? fdv[src] : fdv[src] % (1 << (FW - 2));
  endfunction

  function automatic int sde(int c);
    return sdv[(e_rgb != 0) ? (c / 3) * 3 : c];
  endfunction

  function automatic logic [NCH-1:0] expect_at(int k);
    logic [NCH-1:0] v;
    int tick, f, s;
    tick = k / divv();
    f = tick % nfl();
    s = (tick / nfl()) % NS;
    for (int c = 0; c < NCH; c++) begin
      case (e_mode)
        0: v[c] = (f < fde(c)) && (s < sde(c));
        1: v[c] = (f < fde(c));
        2: v[c] = 1'b1;
        default: v[c] = 1'b0;
      endcase
    end
    return v;
  endfunction

  task automatic check_vec(input logic [NCH-1:0] exp, input string tag, input int k);
    n_chk++;
    if (chan_on !== exp) begin
      n_fail++;
      $display("FAIL %s k=%0d mode=%0d wide=%0d fsel=%0d rgb=%0d: actual %b expected %b",
               tag, k, e_mode, e_wide, e_fsel, e_rgb, chan_on, exp);
    end
  endtask

  task automatic check_int(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic arm(input int w, input int fs, input int m, input int g);
    @(negedge clk);
    run = 1'b0;
    e_wide = w; e_fsel = fs; e_mode = m; e_rgb = g;
    wide_res = w[0]; freq_sel = fs[1:0]; mode_sel = m[1:0]; rgb_group = g[0];
    drive(fdv, sdv);
    @(negedge clk);
    run = 1'b1;
    #1;
  endtask

  task automatic pick_duties();
    for (int c = 0; c < NCH; c++) begin
      fdv[c] = $urandom_range((1 << FW) - 1, 0);
      sdv[c] = $urandom_range(NS - 1, 0);
    end
    fdv[0] = (1 << FW) - 1; sdv[0] = NS - 1;   // full duty corner
    fdv[1] = (1 << (FW - 2));                  // narrow low bits zero
    fdv[2] = 0;                                // zero fast duty
    sdv[4] = 0;                                // zero slow duty
  endtask

  initial begin
    string tag;
    int p;
    int ones[NCH];

    // R10: reset dominates a DC request with full duties
    run = 1'b1; mode_sel = 2'b10; fast_duty = '1; slow_duty = '1;
    repeat (3) @(negedge clk);
    #1;
    check_vec('0, "R10 reset", 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_vec('0, "R10 after reset", 1);

    // R1 R2 R3 R4 R5 R6 R9: sweep of every configuration
    for (int w = 0; w < 2; w++)
      for (int fs = 0; fs < 4; fs++)
        for (int m = 0; m < 4; m++)
          for (int g = 0; g < 2; g++) begin
            pick_duties();
            arm(w, fs, m, g);
            p = divv() * nfl() * NS;
            tag = (m == 0) ? ((w == 0) ? "R1 R2 R3 R4" : "R1 R2 R3") : "R1 R2 R5";
            if (g != 0) tag = {tag, " R6"};
            for (int c = 0; c < NCH; c++) ones[c] = 0;
            for (int k = 0; k < p + 3; k++) begin
              check_vec(expect_at(k), tag, k);
              if (k < p)
                for (int c = 0; c < NCH; c++) ones[c] += int'(chan_on[c]);
              @(negedge clk);
              #1;
            end
            if (m == 0)
              for (int c = 0; c < NCH; c++)
                check_int(ones[c], divv() * fde(c) * sde(c), "R9 on count");
          end

    // R8: mid-period change waits for the boundary
    pick_duties();
    arm(0, 2, 0, 0);
    p = divv() * nfl() * NS;
    for (int c = 0; c < NCH; c++) begin
      nfd[c] = (fdv[c] + 3) % (1 << FW);
      nsd[c] = (sdv[c] + 5) % NS;
    end
    for (int k = 0; k < 2 * p; k++) begin
      if (k == p / 2) begin
        drive(nfd, nsd);
        mode_sel = 2'b01;
      end
      if (k == p) begin
        for (int c = 0; c < NCH; c++) begin
          fdv[c] = nfd[c];
          sdv[c] = nsd[c];
        end
        e_mode = 1;
      end
      check_vec(expect_at(k), "R8 deferred update", k);
      @(negedge clk);
      #1;
    end

    // R7: stop darkens outputs, restart begins at slot 0
    pick_duties();
    arm(1, 0, 0, 0);
    for (int k = 0; k < 40; k++) begin
      check_vec(expect_at(k), "R7 before stop", k);
      @(negedge clk);
      #1;
    end
    mode_sel = 2'b10;
    run = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check_vec('0, "R7 stopped", k);
      @(negedge clk);
    end
    e_mode = 2;
    run = 1'b1;
    #1;
    e_mode = 0;
    mode_sel = 2'b00;
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    run = 1'b1;
    #1;
    for (int k = 0; k < 40; k++) begin
      check_vec(expect_at(k), "R7 restart phase", k);
      @(negedge clk);
      #1;
    end

    finish_up();
  end

endmodule